// File: doc/BRIEF.md
# Two-Channel Link Output Port with Arrival-Order Arbitration

This block is the egress side of one link of a mesh router. Two virtual channels share the physical link. Six sources can compete for each channel: five router input ports (indices 0 to 4) and a routing-modification port (index 5). For each channel, an arbiter records requests in the order they first appear and grants the channel to one source at a time. The grant lasts for a whole packet. A channel multiplexer then places the flits of the two channels onto the link. Each channel has its own downstream credit counter.

The port also supports rerouting a packet after its original path was blocked. The modification port requests the channel like any other source and supplies a rewritten header. Once that header has gone out, the grant moves to the input port named on the channel's handover-target input. That input port supplies the body and tail flits without raising a request of its own. A per-channel flag reports that such a rerouted packet owns the channel.

Top module: `vc_out_port`

## Requirements
- R1: After synchronous reset, no grant, no flit acceptance and no link flit are asserted, the reroute flags are low, and each channel holds 2 credits.
- R2: Per channel, grants follow the order in which requests first appear. Requests that first appear in the same cycle are ordered by ascending source index. A request first seen in cycle c on an idle channel is granted from cycle c+2.
- R3: The flit kind is carried in the top two flit bits: 00 body, 01 head, 10 tail, 11 single-flit packet. A grant is held until a tail or single flit of the owner is accepted. The next queued source is granted from the following cycle.
- R4: A flit is accepted (`flit_ack_o`) only from the channel owner, only while it presents a valid flit, and only in a cycle the multiplexer picks that channel. The accepted flit appears on the link in the next cycle, tagged with its channel.
- R5: When both channels can send in the same cycle, the link alternates between them. After reset, channel 0 has first turn.
- R6: Each channel has a 2-bit credit count. It drops by one per flit sent and rises by one per `credit_i` pulse. A channel sends nothing while its count is zero.
- R7: While source 5 owns a channel, `reconf_o` is high. When source 5's head flit (kind 01) is accepted, the grant moves in the next cycle to the input port given by `rm_tgt_i` in the acceptance cycle. That port's flits, through the tail, are then accepted, and `reconf_o` stays high until that tail is accepted.
- R8: A single-flit packet (kind 11) from source 5 releases the grant with no handover.
- R9: A request held high while its source is queued or granted does not create a second queue entry. A request still high after the source's tail was accepted counts as a new arrival behind those already queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NVC*NSRC | Channel request per source, bit v*NSRC+s |
| flit_vld_i | input | NVC*NSRC | Source has a flit presented on channel v |
| flit_i | input | NVC*NSRC*FW | Presented flits, slice (v*NSRC+s)*FW |
| rm_tgt_i | input | NVC*SRCW | Handover target input port per channel |
| credit_i | input | NVC | Credit return pulse per channel |
| gnt_o | output | NVC*NSRC | Current channel owner, one-hot per channel |
| flit_ack_o | output | NVC*NSRC | Presented flit taken this cycle |
| link_vld_o | output | 1 | Link carries a flit |
| link_vc_o | output | VCW | Channel of the link flit |
| link_flit_o | output | FW | Link flit |
| reconf_o | output | NVC | Rerouted packet owns the channel |

## Verification
A corrupted arrival queue shows up as the wrong bit of `gnt_o` in the cycle after the previous tail leaves. A lost or duplicated entry shows up as a source that is never granted or is granted twice. Bad credit or turn state shows on the link within one cycle, either as a flit tagged with the wrong channel or as a flit sent while credits are exhausted. A handover that picks the wrong port, or drops the owner early, shows at once as a wrong `flit_ack_o` bit and a `reconf_o` mismatch in the cycle after the rewritten header is taken.

// File: rtl/vcop_pkg.sv
package vcop_pkg;

  typedef enum logic [1:0] {
    FK_BODY = 2'b00,
    FK_HEAD = 2'b01,
    FK_TAIL = 2'b10,
    FK_SOLO = 2'b11
  } flit_kind_e;

  function automatic logic ends_packet(flit_kind_e k);
    return (k == FK_TAIL) || (k == FK_SOLO);
  endfunction

endpackage

// File: rtl/vcop_arb.sv
module vcop_arb
  import vcop_pkg::*;
#(
  parameter int NSRC   = 6,
  parameter int QDEPTH = 6,
  localparam int SRCW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req_i,
  input  logic            sent_i,
  input  flit_kind_e      kind_i,
  input  logic [SRCW-1:0] tgt_i,
  output logic            own_vld_o,
  output logic [SRCW-1:0] own_id_o,
  output logic            reconf_o
);

  localparam int CW = $clog2(QDEPTH + 1);
  localparam logic [SRCW-1:0] RM_ID = SRCW'(NSRC - 1);

  logic [SRCW-1:0] q_q [QDEPTH];
  logic [SRCW-1:0] q_n [QDEPTH];
  logic [CW-1:0]   cnt_q, cnt_n;
  logic [NSRC-1:0] inq_q, inq_n, arrive, clr;
  logic            own_vld_q, own_vld_n;
  logic [SRCW-1:0] own_q, own_n;
  logic            handed_q, handed_n;
  logic            reconf_q, reconf_n;
  logic            release_w, hand_w, pop_w;

  always_comb begin
    arrive    = req_i & ~inq_q;
    release_w = sent_i && own_vld_q && ends_packet(kind_i);
    hand_w    = sent_i && own_vld_q && !handed_q && (own_q == RM_ID) && (kind_i == FK_HEAD);
    pop_w     = (cnt_q != '0) && (!own_vld_q || release_w) && !hand_w;

    q_n   = q_q;
    cnt_n = cnt_q;
    if (pop_w) begin
      for (int i = 0; i < QDEPTH - 1; i++) q_n[i] = q_q[i+1];
      cnt_n = cnt_q - CW'(1);
    end
    for (int s = 0; s < NSRC; s++) begin
      if (arrive[s] && (int'(cnt_n) < QDEPTH)) begin
        q_n[cnt_n] = SRCW'(s);
        cnt_n      = cnt_n + CW'(1);
      end
    end

    clr = '0;
    if (release_w && !handed_q) clr[own_q] = 1'b1;
    if (hand_w)                 clr[RM_ID] = 1'b1;
    inq_n = (inq_q | arrive) & ~clr;

    own_vld_n = own_vld_q;
    own_n     = own_q;
    handed_n  = handed_q;
    if (hand_w) begin
      own_n    = tgt_i;
      handed_n = 1'b1;
    end else if (pop_w) begin
      own_vld_n = 1'b1;
      own_n     = q_q[0];
      handed_n  = 1'b0;
    end else if (release_w) begin
      own_vld_n = 1'b0;
      handed_n  = 1'b0;
    end
    reconf_n = own_vld_n && ((own_n == RM_ID) || handed_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      inq_q     <= '0;
      own_vld_q <= 1'b0;
      own_q     <= '0;
      handed_q  <= 1'b0;
      reconf_q  <= 1'b0;
      for (int i = 0; i < QDEPTH; i++) q_q[i] <= '0;
    end else begin
      cnt_q     <= cnt_n;
      inq_q     <= inq_n;
      own_vld_q <= own_vld_n;
      own_q     <= own_n;
      handed_q  <= handed_n;
      reconf_q  <= reconf_n;
      q_q       <= q_n;
    end
  end

  assign own_vld_o = own_vld_q;
  assign own_id_o  = own_q;
  assign reconf_o  = reconf_q;

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) <= QDEPTH);

  // R3
  grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (own_vld_q && !sent_i) |=> (own_vld_q && own_q == $past(own_q)));

  // R3
  next_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (release_w && cnt_q != '0) |=> own_vld_q);

  // R7
  handover_chk: assert property (@(posedge clk) disable iff (rst)
    hand_w |=> (own_vld_q && own_q == $past(tgt_i) && reconf_o));

endmodule

// File: rtl/vcop_mux.sv
module vcop_mux #(
  parameter int NVC     = 2,
  parameter int FW      = 16,
  parameter int CRW     = 2,
  parameter int CR_INIT = 2,
  localparam int VCW    = (NVC > 1) ? $clog2(NVC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NVC-1:0]    rdy_i,
  input  logic [NVC*FW-1:0] flit_i,
  input  logic [NVC-1:0]    credit_i,
  output logic [NVC-1:0]    send_o,
  output logic              link_vld_o,
  output logic [VCW-1:0]    link_vc_o,
  output logic [FW-1:0]     link_flit_o
);

  logic [CRW-1:0] cred_q [NVC];
  logic [NVC-1:0] can;
  logic [VCW-1:0] last_q, pick;
  logic           found;
  logic           lv_q;
  logic [VCW-1:0] lvc_q;
  logic [FW-1:0]  lf_q;

  for (genvar v = 0; v < NVC; v++) begin : g_cred
    assign can[v] = rdy_i[v] && (cred_q[v] != '0);

    always_ff @(posedge clk) begin
      if (rst) cred_q[v] <= CRW'(CR_INIT);
      else     cred_q[v] <= cred_q[v] + CRW'(credit_i[v]) - CRW'(send_o[v]);
    end

    // R6
    credit_bound_chk: assert property (@(posedge clk) disable iff (rst)
      int'(cred_q[v]) <= CR_INIT);

    // R4
    link_follow_chk: assert property (@(posedge clk) disable iff (rst)
      send_o[v] |=> (link_vld_o && int'(link_vc_o) == v));
  end

  always_comb begin
    found  = 1'b0;
    pick   = '0;
    send_o = '0;
    for (int k = 1; k <= NVC; k++) begin
      int idx;
      idx = (int'(last_q) + k) % NVC;
      if (!found && can[idx]) begin
        found = 1'b1;
        pick  = VCW'(idx);
      end
    end
    if (found) send_o[pick] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= VCW'(NVC - 1);
      lv_q   <= 1'b0;
      lvc_q  <= '0;
      lf_q   <= '0;
    end else begin
      lv_q <= found;
      if (found) begin
        last_q <= pick;
        lvc_q  <= pick;
        lf_q   <= flit_i[int'(pick)*FW +: FW];
      end
    end
  end

  assign link_vld_o  = lv_q;
  assign link_vc_o   = lvc_q;
  assign link_flit_o = lf_q;

  // R5
  one_send_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(send_o));

  // R5
  alternate_chk: assert property (@(posedge clk) disable iff (rst)
    (&can && link_vld_o) |-> (pick != link_vc_o));

endmodule

// File: rtl/vc_out_port.sv
module vc_out_port
  import vcop_pkg::*;
#(
  parameter int NSRC    = 6,
  parameter int NVC     = 2,
  parameter int FW      = 16,
  parameter int QDEPTH  = NSRC,
  parameter int CRW     = 2,
  parameter int CR_INIT = 2,
  localparam int SRCW   = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int VCW    = (NVC > 1) ? $clog2(NVC) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NVC*NSRC-1:0]    req_i,
  input  logic [NVC*NSRC-1:0]    flit_vld_i,
  input  logic [NVC*NSRC*FW-1:0] flit_i,
  input  logic [NVC*SRCW-1:0]    rm_tgt_i,
  input  logic [NVC-1:0]         credit_i,
  output logic [NVC*NSRC-1:0]    gnt_o,
  output logic [NVC*NSRC-1:0]    flit_ack_o,
  output logic                   link_vld_o,
  output logic [VCW-1:0]         link_vc_o,
  output logic [FW-1:0]          link_flit_o,
  output logic [NVC-1:0]         reconf_o
);

  logic [NVC-1:0]    rdy, send, own_vld;
  logic [NVC*FW-1:0] own_flit;

  for (genvar v = 0; v < NVC; v++) begin : g_vc
    logic [SRCW-1:0] own_id;
    logic [FW-1:0]   fl;

    assign fl = flit_i[(v*NSRC + int'(own_id))*FW +: FW];
    assign own_flit[v*FW +: FW] = fl;
    assign rdy[v] = own_vld[v] && flit_vld_i[v*NSRC + int'(own_id)];

    vcop_arb #(.NSRC(NSRC), .QDEPTH(QDEPTH)) u_arb (
      .clk       (clk),
      .rst       (rst),
      .req_i     (req_i[v*NSRC +: NSRC]),
      .sent_i    (send[v]),
      .kind_i    (flit_kind_e'(fl[FW-1 -: 2])),
      .tgt_i     (rm_tgt_i[v*SRCW +: SRCW]),
      .own_vld_o (own_vld[v]),
      .own_id_o  (own_id),
      .reconf_o  (reconf_o[v])
    );

    always_comb begin
      gnt_o[v*NSRC +: NSRC]      = '0;
      flit_ack_o[v*NSRC +: NSRC] = '0;
      if (own_vld[v]) begin
        gnt_o[v*NSRC + int'(own_id)]      = 1'b1;
        flit_ack_o[v*NSRC + int'(own_id)] = send[v];
      end
    end

    // R2
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(gnt_o[v*NSRC +: NSRC]));

    // R4
    ack_owner_chk: assert property (@(posedge clk) disable iff (rst)
      ((flit_ack_o[v*NSRC +: NSRC] & ~(gnt_o[v*NSRC +: NSRC] & flit_vld_i[v*NSRC +: NSRC])) == '0));

    // R7
    reconf_owned_chk: assert property (@(posedge clk) disable iff (rst)
      reconf_o[v] |-> (gnt_o[v*NSRC +: NSRC] != '0));
  end

  vcop_mux #(.NVC(NVC), .FW(FW), .CRW(CRW), .CR_INIT(CR_INIT)) u_mux (
    .clk         (clk),
    .rst         (rst),
    .rdy_i       (rdy),
    .flit_i      (own_flit),
    .credit_i    (credit_i),
    .send_o      (send),
    .link_vld_o  (link_vld_o),
    .link_vc_o   (link_vc_o),
    .link_flit_o (link_flit_o)
  );

endmodule

// File: tb/vc_out_port_tb.sv
module vc_out_port_tb;

  localparam int NS = 6;
  localparam int NV = 2;
  localparam int FW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [NV*NS-1:0]    req, vld;
  logic [NV*NS*FW-1:0] flit;
  logic [NV*3-1:0]     rmt;
  logic [NV-1:0]       crd;
  logic [NV*NS-1:0]    gnt, ack;
  logic                lv;
  logic                lvc;
  logic [FW-1:0]       lf;
  logic [NV-1:0]       rcf;

  vc_out_port u_dut (
    .clk(clk), .rst(rst), .req_i(req), .flit_vld_i(vld), .flit_i(flit),
    .rm_tgt_i(rmt), .credit_i(crd), .gnt_o(gnt), .flit_ack_o(ack),
    .link_vld_o(lv), .link_vc_o(lvc), .link_flit_o(lf), .reconf_o(rcf)
  );

  int n_run = 0, n_fail = 0, cyc = 0;

  // source agents
  bit act [NS][NV];
  int len [NS][NV];
  int pos [NS][NV];
  int again [NS][NV];
  bit hdr_only [NS][NV];
  bit noreq [NS][NV];
  // credit return control
  bit hold [NV];
  int owed [NV];
  int tgt [NV];

  // reference model
  int q [NV][$];
  int owner [NV];
  bit handed [NV];
  bit inq [NV][NS];
  int cred [NV];
  int last_vc;
  logic [NV*NS-1:0] e_gnt;
  logic             e_lv;
  logic             e_lvc;
  logic [FW-1:0]    e_lf;
  logic [NV-1:0]    e_rcf;

  function automatic logic [1:0] kind_of(int s, int v);
    if (hdr_only[s][v]) return 2'b01;
    if (noreq[s][v])    return (pos[s][v] == len[s][v]-1) ? 2'b10 : 2'b00;
    if (len[s][v] == 1) return 2'b11;
    if (pos[s][v] == 0) return 2'b01;
    if (pos[s][v] == len[s][v]-1) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [FW-1:0] mk(int s, int v);
    return {kind_of(s, v), 3'(s), 1'(v), 10'(pos[s][v])};
  endfunction

  task automatic chk(bit ok, string tag, logic [255:0] act_v, logic [255:0] exp_v);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act_v, exp_v, cyc);
    end
  endtask

  task automatic model_reset();
    for (int v = 0; v < NV; v++) begin
      q[v].delete();
      owner[v] = -1; handed[v] = 0; cred[v] = 2; owed[v] = 0;
      for (int s = 0; s < NS; s++) inq[v][s] = 0;
    end
    last_vc = 1;
    e_gnt = '0; e_lv = 0; e_lvc = 0; e_lf = '0; e_rcf = '0;
  endtask

  task automatic drive();
    req = '0; vld = '0; flit = '0; crd = '0;
    for (int v = 0; v < NV; v++) begin
      rmt[v*3 +: 3] = 3'(tgt[v]);
      if (lv && int'(lvc) == v) owed[v]++;
      if (!hold[v] && owed[v] > 0) begin crd[v] = 1'b1; owed[v]--; end
      for (int s = 0; s < NS; s++) begin
        req[v*NS+s] = act[s][v] && !noreq[s][v];
        vld[v*NS+s] = act[s][v];
        if (act[s][v]) flit[(v*NS+s)*FW +: FW] = mk(s, v);
      end
    end
  endtask

  task automatic step();
    bit rdy [NV];
    int sv;
    logic [NV*NS-1:0] e_ack;
    for (int v = 0; v < NV; v++)
      rdy[v] = owner[v] >= 0 && act[owner[v]][v] && cred[v] > 0;
    sv = -1;
    if (rdy[0] && rdy[1]) sv = 1 - last_vc;
    else if (rdy[0]) sv = 0;
    else if (rdy[1]) sv = 1;
    e_ack = '0;
    if (sv >= 0) e_ack[sv*NS + owner[sv]] = 1'b1;
    chk(ack == e_ack, "R4 ack", 256'(ack), 256'(e_ack));
    e_lv = (sv >= 0);
    if (sv >= 0) begin
      e_lvc = 1'(sv);
      e_lf = mk(owner[sv], sv);
      last_vc = sv;
    end
    for (int v = 0; v < NV; v++) begin
      bit sent, rel, hand, pop;
      logic [1:0] k;
      int arr [$];
      int o;
      o = owner[v];
      sent = (sv == v);
      k = sent ? kind_of(o, v) : 2'b00;
      rel = sent && (k == 2'b10 || k == 2'b11);
      hand = sent && o == 5 && !handed[v] && k == 2'b01;
      pop = q[v].size() > 0 && (o < 0 || rel) && !hand;
      for (int s = 0; s < NS; s++) if (req[v*NS+s] && !inq[v][s]) arr.push_back(s);
      if (rel && !handed[v]) inq[v][o] = 0;
      if (hand) inq[v][5] = 0;
      if (hand) begin owner[v] = tgt[v]; handed[v] = 1; end
      else if (pop) begin owner[v] = q[v].pop_front(); handed[v] = 0; end
      else if (rel) begin owner[v] = -1; handed[v] = 0; end
      foreach (arr[i]) begin q[v].push_back(arr[i]); inq[v][arr[i]] = 1; end
      cred[v] = cred[v] + int'(crd[v]) - int'(sent);
      // agent advance
      if (sent) begin
        if (rel || hdr_only[o][v]) begin
          if (again[o][v] > 0) begin again[o][v]--; pos[o][v] = 0; end
          else act[o][v] = 0;
        end else pos[o][v]++;
      end
    end
    e_gnt = '0;
    for (int v = 0; v < NV; v++) begin
      if (owner[v] >= 0) e_gnt[v*NS + owner[v]] = 1'b1;
      e_rcf[v] = owner[v] >= 0 && (owner[v] == 5 || handed[v]);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired, actual=hung expected=done");
      summary();
    end
    if (rst) begin
      model_reset();
      drive();
      if (cyc == 4) begin
        #1;
        // R1 reset state
        chk(gnt == '0 && ack == '0 && !lv && rcf == '0, "R1 reset",
            256'({gnt, ack, lv, rcf}), 256'(0));
      end
    end else begin
      chk(gnt == e_gnt, "R2 R3 R7 R8 R9 grant", 256'(gnt), 256'(e_gnt));
      chk(lv == e_lv && (!e_lv || (lvc == e_lvc && lf == e_lf)),
          "R4 R5 R6 link", 256'({lv, lvc, lf}), 256'({e_lv, e_lvc, e_lf}));
      chk(rcf == e_rcf, "R7 R8 reconf", 256'(rcf), 256'(e_rcf));
      drive();
      #1;
      step();
    end
  end

  task automatic start(int s, int v, int l, int rep = 0, bit ho = 0, bit nr = 0);
    len[s][v] = l; pos[s][v] = 0; again[s][v] = rep;
    hdr_only[s][v] = ho; noreq[s][v] = nr; act[s][v] = 1;
  endtask

  task automatic wait_idle();
    bit busy;
    do begin
      @(posedge clk);
      busy = 0;
      for (int v = 0; v < NV; v++) begin
        if (owner[v] >= 0 || q[v].size() > 0 || owed[v] > 0) busy = 1;
        for (int s = 0; s < NS; s++) if (act[s][v]) busy = 1;
      end
    end while (busy);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    for (int s = 0; s < NS; s++)
      for (int v = 0; v < NV; v++) begin
        act[s][v] = 0; len[s][v] = 0; pos[s][v] = 0; again[s][v] = 0;
        hdr_only[s][v] = 0; noreq[s][v] = 0;
      end
    for (int v = 0; v < NV; v++) begin hold[v] = 0; tgt[v] = 0; end
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;

    // R2 R9: same-cycle order, later arrivals, re-request after tail
    @(posedge clk);
    start(3, 0, 3); start(1, 0, 2, 1);
    repeat (2) @(posedge clk);
    start(0, 0, 1); start(4, 0, 2);
    wait_idle();

    // R5: both channels ready together
    @(posedge clk);
    start(2, 0, 4); start(2, 1, 4);
    wait_idle();

    // R6: credit starvation on channel 1
    @(posedge clk);
    hold[1] = 1;
    start(0, 1, 5);
    repeat (8) @(posedge clk);
    hold[1] = 0;
    wait_idle();

    // R7: reroute handover on channel 0, another packet queued behind
    @(posedge clk);
    tgt[0] = 4;
    start(5, 0, 1, 0, 1, 0);
    start(4, 0, 3, 0, 0, 1);
    @(posedge clk);
    start(2, 0, 3);
    wait_idle();

    // R8: single-flit packet from the modification port
    @(posedge clk);
    tgt[1] = 3;
    start(5, 1, 1); start(0, 1, 2);
    wait_idle();

    // mixed traffic on both channels, including a reroute on channel 1
    @(posedge clk);
    tgt[1] = 1;
    for (int s = 0; s < 5; s++) start(s, s % 2, s % 3 + 1);
    start(5, 1, 1, 0, 1, 0);
    start(1, 1, 2, 0, 0, 1);
    wait_idle();

    summary();
  end

endmodule